// File: doc/BRIEF.md
# Operand address and set prediction

This block is the front end of a data-operand access. It accepts a base register value, an index register value and a signed displacement, forms a 64-bit logical address, and then decides which cache way to read without waiting for translation. A history table indexed by low logical-address bits names the way to read. A small direct-mapped TLB and a small four-way tag directory are read in parallel with that table. One stage later, the predicted way is checked against the translated tag.

The access flows through four stages: address generation, two lookup stages and a verify stage. Every accepted access yields exactly one verdict in the verify stage:
- **hit**: the predicted way holds the line.
- **set-mispredict**: another way holds the line. The table entry is retrained to that way and the access is sent back for reissue.
- **miss**: translation failed, or no way holds the line. The access is sent back for reissue.

The pipeline never stalls. The translation and directory contents are loaded through two write ports, normally by a fill path or a bench.

Inside the verify stage the verdict is an enumerated result with four values: idle, hit, set-mispredict and miss. A single `unique case` on the registered verdict drives the output flags. The next-verdict logic has a fixed order:
1. Idle when no access is present.
2. Miss when the TLB misses or no way matches.
3. Hit when the predicted way matches.
4. Set-mispredict otherwise.

Top module: `opa_front`

## Requirements
- R1: The logical address is base + index + sign-extended 20-bit displacement, modulo 2^64. A base or index whose enable is low contributes zero. The address appears on `res_laddr` with the verdict.
- R2: An access captured with `in_valid` high at clock edge N raises `res_valid` for exactly the single cycle that follows edge N+3. `res_valid` is low at all other times, including after reset.
- R3: While `res_valid` is high, exactly one of `res_hit`, `res_setmiss` and `res_miss` is high. While `res_valid` is low, all three flags and `recycle` are low.
- R4: The set-prediction table has one 2-bit way entry per value of logical-address bits 13..4 (1024 entries). All entries reset to way 0, and `res_pred_way` reports the entry that was read.
- R5: The TLB slot is logical-address bits 15..12. The TLB hits when that slot is valid and its stored page number equals address bits 63..12. The directory set is address bits 7..4. When the TLB hits and the predicted way in that set is valid with a tag equal to the TLB physical page number, the verdict is hit and `res_way` equals the predicted way.
- R6: When the TLB hits and the predicted way does not match, but another way does, the verdict is set-mispredict and `res_way` is the lowest matching way. The table entry is rewritten to that way, so an access with the same bits 13..4, issued at least three cycles after the verdict, predicts it.
- R7: A TLB miss, or a TLB hit with no valid matching way, gives the miss verdict with `res_way` = 0.
- R8: On hit or set-mispredict, `res_paddr` is the TLB physical page number (20 bits) concatenated with logical-address bits 11..0.
- R9: A TLB write or directory write changes the verdict of every access captured after the write's clock edge. Valid bits of both structures clear on reset.
- R10: `recycle` is high exactly when the verdict is set-mispredict or miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access present this cycle |
| in_base | input | 64 | Base register value |
| in_base_en | input | 1 | Base participates in the sum |
| in_index | input | 64 | Index register value |
| in_index_en | input | 1 | Index participates in the sum |
| in_disp | input | 20 | Signed displacement |
| tlb_wr_en | input | 1 | Write one TLB slot |
| tlb_wr_slot | input | 4 | TLB slot to write |
| tlb_wr_valid | input | 1 | Valid bit written |
| tlb_wr_vpn | input | 52 | Logical page number written |
| tlb_wr_ppn | input | 20 | Physical page number written |
| dir_wr_en | input | 1 | Write one directory entry |
| dir_wr_set | input | 4 | Directory set to write |
| dir_wr_way | input | 2 | Directory way to write |
| dir_wr_valid | input | 1 | Valid bit written |
| dir_wr_tag | input | 20 | Physical tag written |
| res_valid | output | 1 | Verdict present |
| res_hit | output | 1 | Predicted way correct |
| res_setmiss | output | 1 | Another way holds the line |
| res_miss | output | 1 | Translation or directory miss |
| recycle | output | 1 | Access must be reissued |
| res_pred_way | output | 2 | Way that was predicted |
| res_way | output | 2 | Way that actually matched |
| res_laddr | output | 64 | Logical address of the access |
| res_paddr | output | 32 | Physical address of the access |

## Verification
A corrupted prediction entry does not show up as a wrong hit. It shows up as a set-mispredict verdict, with `res_pred_way` differing from the way the bench model expects, on the first access that touches that entry. A retraining write that is lost or misdirected shows up in the same way on the second access to the index, which then reports set-mispredict again instead of hit. A stale TLB or directory entry turns an expected hit into a miss, or the reverse, four cycles after the access is captured. The result also carries a wrong `res_paddr`, so a translation fault cannot hide behind a correct-looking flag.

// File: rtl/opa_pkg.sv
package opa_pkg;

    typedef enum logic [1:0] {
        RES_IDLE    = 2'd0,
        RES_HIT     = 2'd1,
        RES_SETMISS = 2'd2,
        RES_MISS    = 2'd3
    } res_kind_t;

endpackage

// File: rtl/opa_addr_gen.sv
module opa_addr_gen #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] base,
    input  logic              base_en,
    input  logic [ADDR_W-1:0] index,
    input  logic              index_en,
    input  logic [DISP_W-1:0] disp,
    output logic              s1_valid,
    output logic [ADDR_W-1:0] s1_laddr
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] base_term, index_term, disp_term, sum;

    always_comb begin
        base_term  = base_en  ? base  : '0;
        index_term = index_en ? index : '0;
        disp_term  = {{EXT_W{disp[DISP_W-1]}}, disp};
        sum        = base_term + index_term + disp_term;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_laddr <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_laddr <= sum;
        end
    end

    // R1: a captured zero-displacement access with both terms off yields zero
    assert_zero_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !base_en && !index_en && disp == '0) |=> (s1_laddr == '0));

endmodule

// File: rtl/opa_setpred.sv
module opa_setpred #(
    parameter int IDX_W = 10,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WAY_W-1:0] rd_way,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WAY_W-1:0] wr_way
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [WAY_W-1:0] table_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) table_q[i] <= '0;
            rd_way <= '0;
        end else begin
            rd_way <= table_q[rd_idx];
            if (wr_en) table_q[wr_idx] <= wr_way;
        end
    end

    // R6: a retraining write is held in the table on the following cycle
    assert_learn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (table_q[$past(wr_idx)] == $past(wr_way)));

endmodule

// File: rtl/opa_lookup.sv
module opa_lookup #(
    parameter int VPN_W     = 52,
    parameter int PPN_W     = 20,
    parameter int TLB_IDX_W = 4,
    parameter int DIR_IDX_W = 4,
    parameter int WAYS      = 4,
    parameter int WAY_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [TLB_IDX_W-1:0]        tlb_idx,
    input  logic [DIR_IDX_W-1:0]        dir_idx,
    input  logic                        tlb_wr_en,
    input  logic [TLB_IDX_W-1:0]        tlb_wr_slot,
    input  logic                        tlb_wr_valid,
    input  logic [VPN_W-1:0]            tlb_wr_vpn,
    input  logic [PPN_W-1:0]            tlb_wr_ppn,
    input  logic                        dir_wr_en,
    input  logic [DIR_IDX_W-1:0]        dir_wr_set,
    input  logic [WAY_W-1:0]            dir_wr_way,
    input  logic                        dir_wr_valid,
    input  logic [PPN_W-1:0]            dir_wr_tag,
    output logic                        rd_tlb_v,
    output logic [VPN_W-1:0]            rd_tlb_vpn,
    output logic [PPN_W-1:0]            rd_tlb_ppn,
    output logic [WAYS-1:0]             rd_dir_v,
    output logic [WAYS-1:0][PPN_W-1:0]  rd_dir_tag
);
    localparam int TLB_N = 1 << TLB_IDX_W;
    localparam int SETS  = 1 << DIR_IDX_W;

    logic             tlb_v   [TLB_N];
    logic [VPN_W-1:0] tlb_vpn [TLB_N];
    logic [PPN_W-1:0] tlb_ppn [TLB_N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TLB_N; i++) begin
                tlb_v[i]   <= 1'b0;
                tlb_vpn[i] <= '0;
                tlb_ppn[i] <= '0;
            end
            rd_tlb_v   <= 1'b0;
            rd_tlb_vpn <= '0;
            rd_tlb_ppn <= '0;
        end else begin
            rd_tlb_v   <= tlb_v[tlb_idx];
            rd_tlb_vpn <= tlb_vpn[tlb_idx];
            rd_tlb_ppn <= tlb_ppn[tlb_idx];
            if (tlb_wr_en) begin
                tlb_v[tlb_wr_slot]   <= tlb_wr_valid;
                tlb_vpn[tlb_wr_slot] <= tlb_wr_vpn;
                tlb_ppn[tlb_wr_slot] <= tlb_wr_ppn;
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic             dv   [SETS];
        logic [PPN_W-1:0] dtag [SETS];
        logic             wr_hit_way;

        assign wr_hit_way = dir_wr_en && (dir_wr_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    dv[s]   <= 1'b0;
                    dtag[s] <= '0;
                end
                rd_dir_v[w]   <= 1'b0;
                rd_dir_tag[w] <= '0;
            end else begin
                rd_dir_v[w]   <= dv[dir_idx];
                rd_dir_tag[w] <= dtag[dir_idx];
                if (wr_hit_way) begin
                    dv[dir_wr_set]   <= dir_wr_valid;
                    dtag[dir_wr_set] <= dir_wr_tag;
                end
            end
        end
    end

endmodule

// File: rtl/opa_verify.sv
module opa_verify
    import opa_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int PAGE_LSB = 12,
    parameter int PPN_W    = 20,
    parameter int WAYS     = 4,
    parameter int WAY_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        s3_valid,
    input  logic [ADDR_W-1:0]           s3_laddr,
    input  logic [WAY_W-1:0]            s3_pred,
    input  logic                        tlb_v,
    input  logic [ADDR_W-PAGE_LSB-1:0]  tlb_vpn,
    input  logic [PPN_W-1:0]            tlb_ppn,
    input  logic [WAYS-1:0]             dir_v,
    input  logic [WAYS-1:0][PPN_W-1:0]  dir_tag,
    output logic                        upd_en,
    output logic [WAY_W-1:0]            upd_way,
    output logic                        res_valid,
    output logic                        res_hit,
    output logic                        res_setmiss,
    output logic                        res_miss,
    output logic                        recycle,
    output logic [WAY_W-1:0]            res_pred_way,
    output logic [WAY_W-1:0]            res_way,
    output logic [ADDR_W-1:0]           res_laddr,
    output logic [PPN_W+PAGE_LSB-1:0]   res_paddr
);
    res_kind_t        kind_d, kind_q;
    logic             tlb_hit, found;
    logic [WAYS-1:0]  way_match;
    logic [WAY_W-1:0] match_way;

    assign tlb_hit = tlb_v && (tlb_vpn == s3_laddr[ADDR_W-1:PAGE_LSB]);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_match[w] = tlb_hit && dir_v[w] && (dir_tag[w] == tlb_ppn);
    end

    always_comb begin
        found     = 1'b0;
        match_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) begin
                found     = 1'b1;
                match_way = WAY_W'(w);
            end
        end
        if (!s3_valid)                kind_d = RES_IDLE;
        else if (!found)              kind_d = RES_MISS;
        else if (way_match[s3_pred])  kind_d = RES_HIT;
        else                          kind_d = RES_SETMISS;
    end

    assign upd_en  = (kind_d == RES_SETMISS);
    assign upd_way = match_way;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q       <= RES_IDLE;
            res_way      <= '0;
            res_pred_way <= '0;
            res_laddr    <= '0;
            res_paddr    <= '0;
        end else begin
            kind_q       <= kind_d;
            res_way      <= match_way;
            res_pred_way <= s3_pred;
            res_laddr    <= s3_laddr;
            res_paddr    <= {tlb_ppn, s3_laddr[PAGE_LSB-1:0]};
        end
    end

    always_comb begin
        res_valid   = 1'b0;
        res_hit     = 1'b0;
        res_setmiss = 1'b0;
        res_miss    = 1'b0;
        recycle     = 1'b0;
        unique case (kind_q)
            RES_IDLE:    ;
            RES_HIT:     begin res_valid = 1'b1; res_hit = 1'b1; end
            RES_SETMISS: begin res_valid = 1'b1; res_setmiss = 1'b1; recycle = 1'b1; end
            RES_MISS:    begin res_valid = 1'b1; res_miss = 1'b1; recycle = 1'b1; end
            default:     ;
        endcase
    end

    assert_one_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_hit, res_setmiss, res_miss}) == 1));

    assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_hit || res_setmiss || res_miss || recycle));

    assert_miss_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_way == '0));

endmodule

// File: rtl/opa_front.sv
module opa_front #(
    parameter int ADDR_W    = 64,
    parameter int DISP_W    = 20,
    parameter int PAGE_LSB  = 12,
    parameter int LINE_LSB  = 4,
    parameter int SP_IDX_W  = 10,
    parameter int TLB_IDX_W = 4,
    parameter int DIR_IDX_W = 4,
    parameter int PPN_W     = 20,
    parameter int WAYS      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [ADDR_W-1:0]         in_base,
    input  logic                      in_base_en,
    input  logic [ADDR_W-1:0]         in_index,
    input  logic                      in_index_en,
    input  logic [DISP_W-1:0]         in_disp,
    input  logic                      tlb_wr_en,
    input  logic [TLB_IDX_W-1:0]      tlb_wr_slot,
    input  logic                      tlb_wr_valid,
    input  logic [ADDR_W-PAGE_LSB-1:0] tlb_wr_vpn,
    input  logic [PPN_W-1:0]          tlb_wr_ppn,
    input  logic                      dir_wr_en,
    input  logic [DIR_IDX_W-1:0]      dir_wr_set,
    input  logic [$clog2(WAYS)-1:0]   dir_wr_way,
    input  logic                      dir_wr_valid,
    input  logic [PPN_W-1:0]          dir_wr_tag,
    output logic                      res_valid,
    output logic                      res_hit,
    output logic                      res_setmiss,
    output logic                      res_miss,
    output logic                      recycle,
    output logic [$clog2(WAYS)-1:0]   res_pred_way,
    output logic [$clog2(WAYS)-1:0]   res_way,
    output logic [ADDR_W-1:0]         res_laddr,
    output logic [PPN_W+PAGE_LSB-1:0] res_paddr
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int VPN_W = ADDR_W - PAGE_LSB;

    logic                       s1_v, s2_v, s3_v;
    logic [ADDR_W-1:0]          s1_la, s2_la, s3_la;
    logic [WAY_W-1:0]           c1_pred, s3_pred;
    logic                       c1_tlb_v, s3_tlb_v;
    logic [VPN_W-1:0]           c1_tlb_vpn, s3_tlb_vpn;
    logic [PPN_W-1:0]           c1_tlb_ppn, s3_tlb_ppn;
    logic [WAYS-1:0]            c1_dir_v, s3_dir_v;
    logic [WAYS-1:0][PPN_W-1:0] c1_dir_tag, s3_dir_tag;
    logic                       upd_en;
    logic [WAY_W-1:0]           upd_way;

    opa_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_ag (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .base(in_base), .base_en(in_base_en),
        .index(in_index), .index_en(in_index_en), .disp(in_disp),
        .s1_valid(s1_v), .s1_laddr(s1_la)
    );

    opa_setpred #(.IDX_W(SP_IDX_W), .WAY_W(WAY_W)) u_sp (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(s1_la[LINE_LSB +: SP_IDX_W]), .rd_way(c1_pred),
        .wr_en(upd_en), .wr_idx(s3_la[LINE_LSB +: SP_IDX_W]), .wr_way(upd_way)
    );

    opa_lookup #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .TLB_IDX_W(TLB_IDX_W),
        .DIR_IDX_W(DIR_IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)
    ) u_lk (
        .clk(clk), .rst_n(rst_n),
        .tlb_idx(s1_la[PAGE_LSB +: TLB_IDX_W]),
        .dir_idx(s1_la[LINE_LSB +: DIR_IDX_W]),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_slot(tlb_wr_slot),
        .tlb_wr_valid(tlb_wr_valid), .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn),
        .dir_wr_en(dir_wr_en), .dir_wr_set(dir_wr_set), .dir_wr_way(dir_wr_way),
        .dir_wr_valid(dir_wr_valid), .dir_wr_tag(dir_wr_tag),
        .rd_tlb_v(c1_tlb_v), .rd_tlb_vpn(c1_tlb_vpn), .rd_tlb_ppn(c1_tlb_ppn),
        .rd_dir_v(c1_dir_v), .rd_dir_tag(c1_dir_tag)
    );

    // Stage 2 carries the address beside the lookups; stage 3 holds both for the check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v <= 1'b0;  s2_la <= '0;
            s3_v <= 1'b0;  s3_la <= '0;  s3_pred <= '0;
            s3_tlb_v <= 1'b0;  s3_tlb_vpn <= '0;  s3_tlb_ppn <= '0;
            s3_dir_v <= '0;    s3_dir_tag <= '0;
        end else begin
            s2_v <= s1_v;  s2_la <= s1_la;
            s3_v <= s2_v;  s3_la <= s2_la;  s3_pred <= c1_pred;
            s3_tlb_v <= c1_tlb_v;  s3_tlb_vpn <= c1_tlb_vpn;  s3_tlb_ppn <= c1_tlb_ppn;
            s3_dir_v <= c1_dir_v;  s3_dir_tag <= c1_dir_tag;
        end
    end

    opa_verify #(
        .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .PPN_W(PPN_W),
        .WAYS(WAYS), .WAY_W(WAY_W)
    ) u_vf (
        .clk(clk), .rst_n(rst_n),
        .s3_valid(s3_v), .s3_laddr(s3_la), .s3_pred(s3_pred),
        .tlb_v(s3_tlb_v), .tlb_vpn(s3_tlb_vpn), .tlb_ppn(s3_tlb_ppn),
        .dir_v(s3_dir_v), .dir_tag(s3_dir_tag),
        .upd_en(upd_en), .upd_way(upd_way),
        .res_valid(res_valid), .res_hit(res_hit), .res_setmiss(res_setmiss),
        .res_miss(res_miss), .recycle(recycle), .res_pred_way(res_pred_way),
        .res_way(res_way), .res_laddr(res_laddr), .res_paddr(res_paddr)
    );

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid, 4));

    assert_hit_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_way == res_pred_way));

    assert_setmiss_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_setmiss |-> (res_way != res_pred_way));

endmodule

// File: tb/sim_opa_front.sv
`timescale 1ns/1ps
module sim_opa_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_base = '0, in_index = '0;
    logic        in_base_en = 1'b0, in_index_en = 1'b0;
    logic [19:0] in_disp = '0;
    logic        tlb_wr_en = 1'b0, tlb_wr_valid = 1'b0;
    logic [3:0]  tlb_wr_slot = '0;
    logic [51:0] tlb_wr_vpn = '0;
    logic [19:0] tlb_wr_ppn = '0;
    logic        dir_wr_en = 1'b0, dir_wr_valid = 1'b0;
    logic [3:0]  dir_wr_set = '0;
    logic [1:0]  dir_wr_way = '0;
    logic [19:0] dir_wr_tag = '0;
    logic        res_valid, res_hit, res_setmiss, res_miss, recycle;
    logic [1:0]  res_pred_way, res_way;
    logic [63:0] res_laddr;
    logic [31:0] res_paddr;

    int n_total = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model of the loaded state and the prediction table
    logic        m_tv   [16];
    logic [51:0] m_tvpn [16];
    logic [19:0] m_tppn [16];
    logic        m_dv   [16][4];
    logic [19:0] m_dtag [16][4];
    logic [1:0]  m_sp   [1024];

    always #2.5 clk = ~clk;

    opa_front u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_base(in_base), .in_base_en(in_base_en),
        .in_index(in_index), .in_index_en(in_index_en), .in_disp(in_disp),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_slot(tlb_wr_slot), .tlb_wr_valid(tlb_wr_valid),
        .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn),
        .dir_wr_en(dir_wr_en), .dir_wr_set(dir_wr_set), .dir_wr_way(dir_wr_way),
        .dir_wr_valid(dir_wr_valid), .dir_wr_tag(dir_wr_tag),
        .res_valid(res_valid), .res_hit(res_hit), .res_setmiss(res_setmiss),
        .res_miss(res_miss), .recycle(recycle), .res_pred_way(res_pred_way),
        .res_way(res_way), .res_laddr(res_laddr), .res_paddr(res_paddr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] sext(input logic [19:0] d);
        return {{44{d[19]}}, d};
    endfunction

    // kind: 1 hit, 2 set-mispredict, 3 miss
    function automatic void model(input logic [63:0] la, output int kind,
                                  output logic [1:0] way, output logic [1:0] pred,
                                  output logic [31:0] pa);
        int ti, st, mw;
        bit th;
        ti   = int'(la[15:12]);
        st   = int'(la[7:4]);
        pred = m_sp[la[13:4]];
        th   = m_tv[ti] && (m_tvpn[ti] == la[63:12]);
        mw   = -1;
        for (int w = 3; w >= 0; w--)
            if (th && m_dv[st][w] && m_dtag[st][w] == m_tppn[ti]) mw = w;
        pa = {m_tppn[ti], la[11:0]};
        if (mw < 0) begin
            kind = 3; way = 2'd0;
        end else begin
            way  = 2'(mw);
            kind = (th && m_dv[st][pred] && m_dtag[st][pred] == m_tppn[ti]) ? 1 : 2;
        end
    endfunction

    task automatic load_tlb(input int slot, input bit v, input logic [51:0] vpn, input logic [19:0] ppn);
        @(negedge clk);
        tlb_wr_en = 1'b1; tlb_wr_slot = 4'(slot); tlb_wr_valid = v;
        tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
        @(negedge clk);
        tlb_wr_en = 1'b0;
        m_tv[slot] = v; m_tvpn[slot] = vpn; m_tppn[slot] = ppn;
    endtask

    task automatic load_dir(input int st, input int w, input bit v, input logic [19:0] tag);
        @(negedge clk);
        dir_wr_en = 1'b1; dir_wr_set = 4'(st); dir_wr_way = 2'(w);
        dir_wr_valid = v; dir_wr_tag = tag;
        @(negedge clk);
        dir_wr_en = 1'b0;
        m_dv[st][w] = v; m_dtag[st][w] = tag;
    endtask

    task automatic run_op(input logic [63:0] b, input bit be, input logic [63:0] x,
                          input bit xe, input logic [19:0] d, output int kind_o);
        logic [63:0] la;
        logic [1:0]  way, pred;
        logic [31:0] pa;
        int kind;
        la = (be ? b : 64'd0) + (xe ? x : 64'd0) + sext(d);
        model(la, kind, way, pred, pa);
        @(negedge clk);
        in_valid = 1'b1; in_base = b; in_base_en = be;
        in_index = x; in_index_en = xe; in_disp = d;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(res_valid == 1'b0, "R2 early valid", 64'(res_valid), 64'd0);
        @(negedge clk);
        chk(res_valid == 1'b1, "R2 valid", 64'(res_valid), 64'd1);
        chk(res_laddr == la, "R1 laddr", res_laddr, la);
        chk({res_hit, res_setmiss, res_miss} == (kind == 1 ? 3'b100 : kind == 2 ? 3'b010 : 3'b001),
            "R3 R5 R6 R7 verdict", 64'({res_hit, res_setmiss, res_miss}), 64'(kind));
        chk(recycle == (kind != 1), "R10 recycle", 64'(recycle), 64'(kind != 1));
        chk(res_pred_way == pred, "R4 pred way", 64'(res_pred_way), 64'(pred));
        chk(res_way == way, "R5 R6 R7 way", 64'(res_way), 64'(way));
        if (kind != 3) chk(res_paddr == pa, "R8 paddr", 64'(res_paddr), 64'(pa));
        @(negedge clk);
        chk(res_valid == 1'b0 && recycle == 1'b0, "R2 R3 single pulse", 64'(res_valid), 64'd0);
        if (kind == 2) m_sp[la[13:4]] = way;
        kind_o = kind;
    endtask

    initial begin
        #750000;
        if (!done) begin
            n_total++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        int k;
        logic [63:0] la, x, b;
        logic [19:0] d;
        bit xe;
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) begin
            m_tv[i] = 1'b0; m_tvpn[i] = '0; m_tppn[i] = '0;
            for (int w = 0; w < 4; w++) begin m_dv[i][w] = 1'b0; m_dtag[i][w] = '0; end
        end
        for (int i = 0; i < 1024; i++) m_sp[i] = 2'd0;

        repeat (4) @(negedge clk);
        chk({res_valid, res_hit, res_setmiss, res_miss, recycle} == 5'b0,
            "R2 R3 reset outputs", 64'({res_valid, res_hit, res_setmiss, res_miss, recycle}), 64'd0);
        rst_n = 1'b1;

        // R9: empty structures after reset make every access miss
        run_op(64'h0000_1234_5678_9000, 1'b1, 64'd0, 1'b0, 20'd0, k);
        chk(k == 3, "R9 reset miss", 64'(k), 64'd3);

        for (int i = 0; i < 16; i++)
            load_tlb(i, i != 5, {32'($urandom), 16'($urandom), 4'(i)}, {16'($urandom), 4'(i)});
        for (int st = 0; st < 16; st++)
            for (int w = 0; w < 4; w++)
                load_dir(st, w, ((st + w) % 7) != 0, m_tppn[(st + 3 * w) % 16]);

        // R1: wrap modulo 2^64
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'd1, 1'b1, 20'd0, k);
        // R1: both terms disabled, negative displacement only
        run_op(64'hDEAD, 1'b0, 64'hBEEF, 1'b0, 20'hFFFF0, k);

        // R6: set 1 holds slot-4 page in way 1; prediction starts at way 0
        la = {m_tvpn[4], 4'h0, 4'h1, 4'h0};
        run_op(la, 1'b1, 64'd0, 1'b0, 20'd0, k);
        chk(k == 2, "R6 first access mispredicts", 64'(k), 64'd2);
        run_op(la - 64'd40, 1'b1, 64'd40, 1'b1, 20'd0, k);
        chk(k == 1, "R6 retrained access hits", 64'(k), 64'd1);

        // R7: directory miss, set 2 has no slot-4 tag
        run_op({m_tvpn[4], 4'h0, 4'h2, 4'h0}, 1'b1, 64'd0, 1'b0, 20'd0, k);
        chk(k == 3, "R7 directory miss", 64'(k), 64'd3);
        // R7: TLB miss on invalid slot 5
        la = {m_tvpn[5], 4'h0, 4'h5, 4'h0};
        run_op(la, 1'b1, 64'd0, 1'b0, 20'd0, k);
        chk(k == 3, "R7 tlb miss", 64'(k), 64'd3);
        // R9: reload slot 5 valid, same access now hits in way 0
        load_tlb(5, 1'b1, m_tvpn[5], m_tppn[5]);
        run_op(la, 1'b1, 64'd0, 1'b0, 20'd0, k);
        chk(k == 1, "R9 reload hit", 64'(k), 64'd1);

        // Constrained random mix of targeted and arbitrary accesses
        for (int n = 0; n < 300; n++) begin
            int ti;
            d  = 20'($urandom);
            xe = 1'($urandom);
            x  = {32'($urandom), 32'($urandom)};
            if (($urandom % 10) < 7) begin
                ti = int'($urandom % 16);
                la = {m_tvpn[ti], 4'($urandom), 4'($urandom), 4'($urandom)};
                b  = la - (xe ? x : 64'd0) - sext(d);
                run_op(b, 1'b1, x, xe, d, k);
            end else begin
                b = {32'($urandom), 32'($urandom)};
                run_op(b, 1'($urandom), x, xe, d, k);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule